// File: doc/BRIEF.md
# Complementary Dead-Time PWM Timer

This block is a 16-bit up-counting timer that produces a pulse-width modulated signal on one pin and its complement on a second pin. Both pins are held apart by a programmable guard gap. The counter advances on a clock enable from a power-of-two prescaler. When the count equals the match value, the waveform changes phase. When the count equals the reload value, the period ends, the count restarts at one, and a single-cycle interrupt pulse is raised.

Software sets the block up while it is disabled. It picks the polarity, the prescale exponent, the match, reload and guard values, and loads a starting count through a write strobe. It then enables the block. The first period runs from the loaded count. Every later period runs from one to the reload value, so a period lasts reload prescaled ticks. Each pin's rise is held back by the guard delay, in undivided system clocks, while falls pass through at once. This leaves a gap in which neither pin is high.

Top module: `cpwm_timer`

## Requirements
- R1: With prescale exponent N, a period lasts reload × 2^N system clocks, and one `irq` pulse is seen per period.
- R2: With `pol`=0, the undelayed primary signal is low while the count runs from 1 to the match value and high from match+1 to the reload value. Over one period it is high for (reload − match) × 2^N clocks, and the pin is high for that time minus the guard delay.
- R3: When the count equals the reload value, the count becomes 0x0001 and `irq` is high for exactly one system clock.
- R4: With `pol`=1, the primary signal is inverted: it is high from 1 to the match value and low after it. Its high time per period is match × 2^N clocks.
- R5: With a guard delay of 0, `pwm_n` equals the inverse of `pwm_p` on every clock while the block is enabled.
- R6: A pin's rise is delayed by exactly `dead` system clocks relative to a zero delay. Its fall follows the undelayed signal one clock after it changes. The two pins are never high together.
- R7: A `dead` value above 128 acts as 128.
- R8: While `en` is low, both pins and `irq` are low, and the count holds its value. A `start_wr` pulse loads `start_val`. After enable, the first `irq` comes reload − start_val + 1 ticks later.
- R9: The prescaler (`presc` = N, 0 to 7) issues one counter tick every 2^N system clocks. The guard counter runs on every system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Timer run enable |
| pol | input | 1 | Output polarity select |
| presc | input | 3 | Prescale exponent N (divide by 2^N) |
| start_wr | input | 1 | Load strobe for the starting count, honoured only while disabled |
| start_val | input | 16 | Starting count |
| match_val | input | 16 | Phase-change compare value |
| reload_val | input | 16 | Period-end compare value |
| dead | input | 8 | Guard delay in system clocks (0 to 128) |
| pwm_p | output | 1 | Primary PWM pin |
| pwm_n | output | 1 | Complementary PWM pin |
| irq | output | 1 | One-clock pulse at each reload |

## Verification
The assertions assume the configuration inputs are steady while `en` is high. They also assume the match value lies strictly between 0 and the reload value, and that the effective guard delay is shorter than both phases of the waveform. Under those conditions every rise finishes its wait before the opposite pin rises. The stimulus changes configuration only after dropping `en`. Every vector is chosen so that both phases, in system clocks, exceed the guard delay, including the vector whose delay value is clamped.

// File: rtl/cpwm_pkg.sv
// Shared widths and limits for the complementary PWM timer.
package cpwm_pkg;
    localparam int CNT_W  = 16;   // counter and compare width
    localparam int PS_W   = 3;    // prescale exponent width
    localparam int DB_W   = 8;    // guard delay width
    localparam int DB_MAX = 128;  // largest honoured guard delay
endpackage

// File: rtl/cpwm_prescaler.sv
// Power-of-two clock enable. Emits one tick every 2^sel clocks while en is
// high and restarts its phase whenever en is low.
// Assumes sel is steady while en is high.
module cpwm_prescaler #(
    parameter int PS_W = cpwm_pkg::PS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [PS_W-1:0] sel,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Low-bit mask that selects the division ratio.
    always_comb mask = DIV_W'((1 << sel) - 1);

    // Free-running divider, cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) div_q <= '0;
        else               div_q <= div_q + 1'b1;
    end

    assign tick = en && ((div_q & mask) == mask);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tick) && sel != '0 && $stable(sel) && $past(en)) |-> !tick); // R9
endmodule

// File: rtl/cpwm_counter.sv
// Period counter. Counts up on ticks, flips the phase at the match value,
// and at the reload value restarts at one, clears the phase and pulses irq.
// While disabled it holds its count and accepts a starting-count load.
module cpwm_counter #(
    parameter int CNT_W = cpwm_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             start_wr,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] match_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic             phase,
    output logic             irq
);
    logic [CNT_W-1:0] cnt;

    // Count, phase and interrupt update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= CNT_W'(1);
            phase <= 1'b0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (!en) begin
                phase <= 1'b0;
                if (start_wr) cnt <= start_val;
            end else if (tick) begin
                if (cnt == reload_val) begin
                    cnt   <= CNT_W'(1);
                    phase <= 1'b0;
                    irq   <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                    if (cnt == match_val) phase <= ~phase;
                end
            end
        end
    end

    AST_RELOAD_TO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cnt == CNT_W'(1)); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !start_wr) |=> $stable(cnt)); // R8
endmodule

// File: rtl/cpwm_deadband.sv
// Rise-delay stage for one pin. A rise of raw loads a down-counter with the
// delay, and the pin goes high when the wait ends. A fall of raw drops the
// pin on the next clock and cancels any pending rise.
// Assumes delay is at most DB_MAX and is steady while en is high.
module cpwm_deadband #(
    parameter int DB_W   = cpwm_pkg::DB_W,
    parameter int DB_MAX = cpwm_pkg::DB_MAX
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            raw,
    input  logic [DB_W-1:0] delay,
    output logic            pin
);
    logic            raw_q;
    logic [DB_W-1:0] left;

    // Edge detect, wait countdown and pin register.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            raw_q <= 1'b0;
            left  <= '0;
            pin   <= 1'b0;
        end else begin
            raw_q <= raw;
            if (!raw) begin
                pin  <= 1'b0;
                left <= '0;
            end else if (!raw_q) begin
                left <= delay;
                pin  <= (delay == '0);
            end else if (!pin) begin
                if (left <= DB_W'(1)) begin
                    pin  <= 1'b1;
                    left <= '0;
                end else begin
                    left <= left - 1'b1;
                end
            end
        end
    end

    AST_FALL_UNDELAYED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !raw) |=> !pin); // R6
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pin); // R8
    AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        left <= DB_W'(DB_MAX)); // R7
endmodule

// File: rtl/cpwm_timer.sv
// Complementary PWM timer top. A prescaler feeds a period counter whose
// phase, XORed with the polarity, forms the primary signal. Its inverse forms
// the complement, and each passes through its own rise-delay stage.
// Assumes configuration is changed only while en is low.
module cpwm_timer
    import cpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pol,
    input  logic [PS_W-1:0]  presc,
    input  logic             start_wr,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] match_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [DB_W-1:0]  dead,
    output logic             pwm_p,
    output logic             pwm_n,
    output logic             irq
);
    localparam int NPIN = 2;

    logic            tick;
    logic            phase;
    logic [DB_W-1:0] dead_eff;
    logic [NPIN-1:0] raw;
    logic [NPIN-1:0] pins;

    cpwm_prescaler #(.PS_W(PS_W)) i_presc (
        .clk(clk), .rst_n(rst_n), .en(en), .sel(presc), .tick(tick)
    );

    cpwm_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
        .start_wr(start_wr), .start_val(start_val),
        .match_val(match_val), .reload_val(reload_val),
        .phase(phase), .irq(irq)
    );

    // Clamp the guard delay and form the two undelayed signals.
    always_comb begin
        dead_eff = (dead > DB_W'(DB_MAX)) ? DB_W'(DB_MAX) : dead;
        raw[0]   = phase ^ pol;
        raw[1]   = ~raw[0];
    end

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        cpwm_deadband #(.DB_W(DB_W), .DB_MAX(DB_MAX)) i_db (
            .clk(clk), .rst_n(rst_n), .en(en),
            .raw(raw[g]), .delay(dead_eff), .pin(pins[g])
        );
    end

    assign pwm_p = pins[0];
    assign pwm_n = pins[1];

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_p && pwm_n)); // R6
    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $stable(dead) && dead == '0) |-> (pwm_n != pwm_p)); // R5
endmodule

// File: tb/test_cpwm_timer.sv
module test_cpwm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, pol = 1'b0, start_wr = 1'b0;
    logic [2:0]  presc = '0;
    logic [15:0] start_val = '0, match_val = 16'd4, reload_val = 16'd10;
    logic [7:0]  dead = '0;
    logic        pwm_p, pwm_n, irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    cpwm_timer i_cpwm_timer (
        .clk(clk), .rst_n(rst_n), .en(en), .pol(pol), .presc(presc),
        .start_wr(start_wr), .start_val(start_val), .match_val(match_val),
        .reload_val(reload_val), .dead(dead),
        .pwm_p(pwm_p), .pwm_n(pwm_n), .irq(irq)
    );

    typedef struct packed {
        logic        v_pol;
        logic [2:0]  v_ps;
        logic [15:0] v_match;
        logic [15:0] v_reload;
        logic [7:0]  v_dead;
        logic [31:0] e_per;
        logic [31:0] e_p;
        logic [31:0] e_n;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 16'd4,   16'd10,  8'd0,   32'd10,  32'd6,   32'd4},
        '{1'b1, 3'd0, 16'd4,   16'd10,  8'd0,   32'd10,  32'd4,   32'd6},
        '{1'b0, 3'd0, 16'd10,  16'd20,  8'd3,   32'd20,  32'd7,   32'd7},
        '{1'b0, 3'd2, 16'd5,   16'd8,   8'd2,   32'd32,  32'd10,  32'd18},
        '{1'b1, 3'd1, 16'd6,   16'd16,  8'd5,   32'd32,  32'd7,   32'd15},
        '{1'b0, 3'd0, 16'd200, 16'd500, 8'd200, 32'd500, 32'd172, 32'd72},
        '{1'b0, 3'd3, 16'd1,   16'd3,   8'd0,   32'd24,  32'd16,  32'd8}
    };

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic wait_irq();
        do @(negedge clk); while (!irq);
    endtask

    task automatic setup(input logic p, input logic [2:0] ps, input logic [15:0] m,
                         input logic [15:0] r, input logic [7:0] d, input logic [15:0] s);
        @(negedge clk);
        en = 1'b0;
        pol = p; presc = ps; match_val = m; reload_val = r; dead = d;
        start_val = s; start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
        en = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog R1: actual %0d cycles expected fewer", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int k;
        int mism;
        repeat (3) @(negedge clk);
        // Reset state
        check("R8 reset pwm_p", int'(pwm_p), 0);
        check("R8 reset pwm_n", int'(pwm_n), 0);
        check("R3 reset irq", int'(irq), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: period, high times and overlap per vector
        for (int i = 0; i < NV; i++) begin
            int per, hp, hn, both;
            setup(VECS[i].v_pol, VECS[i].v_ps, VECS[i].v_match,
                  VECS[i].v_reload, VECS[i].v_dead, 16'd1);
            wait_irq();
            wait_irq();
            per = 0; hp = 0; hn = 0; both = 0;
            do begin
                @(negedge clk);
                per++;
                hp += int'(pwm_p);
                hn += int'(pwm_n);
                both += int'(pwm_p & pwm_n);
            end while (!irq);
            check($sformatf("R1 R9 period vec%0d", i), per, int'(VECS[i].e_per));
            check($sformatf("R2 R4 R7 pwm_p high vec%0d", i), hp, int'(VECS[i].e_p));
            check($sformatf("R6 pwm_n high vec%0d", i), hn, int'(VECS[i].e_n));
            check($sformatf("R6 overlap vec%0d", i), both, 0);
        end

        // R5: complement relation with zero guard delay
        setup(1'b0, 3'd0, 16'd4, 16'd10, 8'd0, 16'd1);
        wait_irq();
        mism = 0;
        for (int j = 0; j < 25; j++) begin
            @(negedge clk);
            mism += int'(pwm_n == pwm_p);
        end
        check("R5 complement mismatches", mism, 0);

        // R6: exact rise timing with zero delay
        wait_irq();
        k = 0;
        do begin @(negedge clk); k++; end while (!pwm_p);
        check("R6 rise latency dead=0", k, 5);

        // R6: rise delayed by 3, fall not delayed
        setup(1'b0, 3'd0, 16'd4, 16'd10, 8'd3, 16'd1);
        wait_irq();
        wait_irq();
        k = 0;
        do begin @(negedge clk); k++; end while (!pwm_p);
        check("R6 rise latency dead=3", k, 8);
        wait_irq();
        check("R6 pwm_p high at reload", int'(pwm_p), 1);
        k = 0;
        do begin @(negedge clk); k++; end while (!pwm_n);
        check("R6 pwm_n rise latency dead=3", k, 4);
        check("R6 pwm_p fell undelayed", int'(pwm_p), 0);

        // R3: irq lasts one clock
        wait_irq();
        @(negedge clk);
        check("R3 irq single cycle", int'(irq), 0);

        // R8: disabling drops both pins
        en = 1'b0;
        @(negedge clk);
        check("R8 idle pwm_p", int'(pwm_p), 0);
        check("R8 idle pwm_n", int'(pwm_n), 0);

        // R8: first period starts from the loaded count
        setup(1'b0, 3'd0, 16'd10, 16'd50, 8'd0, 16'd48);
        k = 0;
        do begin @(negedge clk); k++; end while (!irq);
        check("R8 first period from start count", k, 3);

        @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule